// File: doc/BRIEF.md
# Chainable Four-Channel Interval Timer

This block holds four 16-bit up-counters that share one write port and one read port. Each channel has its own reload value and control settings. A running channel advances on one of two sources. The first is a divided copy of a system tick enable, divided by 1, 64, 256 or 1024. The second is the overflow of the channel just below it. When a count steps past its all-ones value, the channel loads its reload value again and, if enabled, pulses its interrupt line.

Chained channels let software build counters wider than 16 bits. A single overflow can pass through several chained stages within one clock cycle. Each stage that wraps reloads and may interrupt. The pass stops at the first stage that does not wrap. The highest channel feeds nothing. Software programs the reload value first and then sets the run bit to start a channel. It reads the live count back through the read port.

Top module: `timer_bank`

## Requirements
- R1: Control bits [1:0] pick the divider: 0 → every tick_en cycle, 1 → every 64th, 2 → every 256th, 3 → every 1024th. The divider of a channel is cleared when that channel starts, so the first increment falls on exactly the Nth tick_en cycle after the start.
- R2: Setting control bit 7 (run) when it was clear loads the count from the reload register. The start cycle itself does not count.
- R3: Writing the control register of a running channel with bit 7 still set takes the new divider and mode bits but leaves the count unchanged.
- R4: A channel that advances from 0xFFFF takes its reload value instead of wrapping to zero.
- R5: When control bit 6 is set, every overflow of the channel raises its irq bit for exactly one cycle. That cycle starts at the same clock edge at which the count takes the reload value. With bit 6 clear, irq stays low.
- R6: A running channel with control bit 2 (chain) set ignores tick_en. It advances by one only when the next-lower channel overflows.
- R7: One overflow ripples through chained channels in the same clock edge, and each wrapping stage reloads and may interrupt. The ripple ends at the first stage that does not wrap, and stages above it keep their count.
- R8: Channel 3 passes no carry onward, so its overflows never move channel 0. A chained channel 0 has no lower neighbour and never advances.
- R9: Writing the reload register of a running channel leaves the current count alone. The new value is used at the next overflow or start.
- R10: rd_data shows the count of channel rd_ch as sampled at the previous clock edge. A stopped channel (bit 7 clear) holds its count.
- R11: After reset all counts, reload values and control fields are zero, and irq and rd_data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Base count enable that feeds the dividers |
| wr_en | input | 1 | Register write strobe |
| wr_ctrl | input | 1 | 1 selects the control register, 0 selects the reload register |
| wr_ch | input | 2 | Channel addressed by the write |
| wr_data | input | 16 | Write data; bits [7:0] are used for control |
| rd_ch | input | 2 | Channel whose count is returned |
| rd_data | output | 16 | Registered count of channel rd_ch |
| irq | output | 4 | One-cycle overflow interrupt pulse per channel |

## Verification
The assertions check, on every cycle, that an interrupt only follows a step from 0xFFFF. They also check that a stopped channel keeps its count, that a running count moves by at most one or jumps to its reload value, that a start loads the reload value, and that a chained channel 0 stays frozen. Only the bench scenarios can show the exact divider periods, that a write to a running channel leaves the count in place, that a new reload value waits for the next overflow, and that a ripple stops at the right stage in the same cycle.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;

  localparam int PS_LSB   = 0;
  localparam int CHAIN_B  = 2;
  localparam int IRQEN_B  = 6;
  localparam int RUN_B    = 7;
  localparam int CTRL_W   = 8;

  typedef struct packed {
    logic       run;
    logic       irq_en;
    logic       chain;
    logic [1:0] div_sel;
  } tmr_ctrl_t;

  function automatic tmr_ctrl_t unpack_ctrl(input logic [CTRL_W-1:0] raw);
    tmr_ctrl_t c;
    c.run     = raw[RUN_B];
    c.irq_en  = raw[IRQEN_B];
    c.chain   = raw[CHAIN_B];
    c.div_sel = raw[PS_LSB +: 2];
    return c;
  endfunction

  function automatic int unsigned div_shift(input logic [1:0] sel);
    case (sel)
      2'd0:    return 0;
      2'd1:    return 6;
      2'd2:    return 8;
      default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
  parameter int DIV_W = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       start,
  input  logic       tick_en,
  input  logic [1:0] sel,
  output logic       pulse
);
  import timer_bank_pkg::*;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_comb begin
    mask = DIV_W'((1 << div_shift(sel)) - 1);
  end

  always_ff @(posedge clk) begin
    if (rst || start) begin
      div_q <= '0;
    end else if (run && tick_en) begin
      div_q <= div_q + 1'b1;
    end
  end

  assign pulse = run && tick_en && ((div_q & mask) == mask);

endmodule

// File: rtl/timer_channel.sv
module timer_channel #(
  parameter int CNT_W = 16,
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_reload,
  input  logic             wr_cfg,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             tick_en,
  input  logic             carry_in,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] reload_o,
  output logic             run_o,
  output logic             chain_o,
  output logic             irq_en_o,
  output logic             ovf_o
);
  import timer_bank_pkg::*;

  tmr_ctrl_t        ctrl_q;
  tmr_ctrl_t        ctrl_new;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload_q;
  logic             start;
  logic             div_pulse;
  logic             step;

  assign ctrl_new = unpack_ctrl(wr_data[CTRL_W-1:0]);
  assign start    = wr_cfg && ctrl_new.run && !ctrl_q.run;

  timer_prescaler #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .run     (ctrl_q.run),
    .start   (start),
    .tick_en (tick_en),
    .sel     (ctrl_q.div_sel),
    .pulse   (div_pulse)
  );

  assign step  = ctrl_q.run && (ctrl_q.chain ? carry_in : div_pulse);
  assign ovf_o = step && (cnt_q == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (wr_reload) reload_q <= wr_data;
      if (wr_cfg)    ctrl_q   <= ctrl_new;
      if (start) begin
        cnt_q <= reload_q;
      end else if (ovf_o) begin
        cnt_q <= reload_q;
      end else if (step) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign count_o  = cnt_q;
  assign reload_o = reload_q;
  assign run_o    = ctrl_q.run;
  assign chain_o  = ctrl_q.chain;
  assign irq_en_o = ctrl_q.irq_en;

endmodule

// File: rtl/timer_bank.sv
module timer_bank #(
  parameter int N_CH  = 4,
  parameter int CNT_W = 16,
  parameter int DIV_W = 10,
  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             wr_en,
  input  logic             wr_ctrl,
  input  logic [CH_W-1:0]  wr_ch,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [CH_W-1:0]  rd_ch,
  output logic [CNT_W-1:0] rd_data,
  output logic [N_CH-1:0]  irq
);

  logic [N_CH-1:0][CNT_W-1:0] cnt_v;
  logic [N_CH-1:0][CNT_W-1:0] reload_v;
  logic [N_CH-1:0]            run_v;
  logic [N_CH-1:0]            casc_v;
  logic [N_CH-1:0]            ien_v;
  logic [N_CH-1:0]            ovf_v;
  logic [CNT_W-1:0]           rd_q;
  logic [N_CH-1:0]            irq_q;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic carry;
    logic ovf_l;
    logic sel_hit;

    assign sel_hit = wr_en && (wr_ch == CH_W'(i));

    if (i == 0) begin : g_first
      assign carry = 1'b0;
    end else begin : g_link
      assign carry = g_ch[i-1].ovf_l;
    end

    timer_channel #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .wr_reload (sel_hit && !wr_ctrl),
      .wr_cfg    (sel_hit && wr_ctrl),
      .wr_data   (wr_data),
      .tick_en   (tick_en),
      .carry_in  (carry),
      .count_o   (cnt_v[i]),
      .reload_o  (reload_v[i]),
      .run_o     (run_v[i]),
      .chain_o   (casc_v[i]),
      .irq_en_o  (ien_v[i]),
      .ovf_o     (ovf_l)
    );

    assign ovf_v[i] = ovf_l;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= '0;
      irq_q <= '0;
    end else begin
      rd_q  <= cnt_v[rd_ch];
      irq_q <= ovf_v & ien_v;
    end
  end

  assign rd_data = rd_q;
  assign irq     = irq_q;

endmodule

// File: rtl/timer_bank_chk.sv
module timer_bank_chk #(
  parameter int N_CH  = 4,
  parameter int CNT_W = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic [N_CH-1:0]            irq,
  input logic [N_CH-1:0][CNT_W-1:0] cnt,
  input logic [N_CH-1:0][CNT_W-1:0] reload,
  input logic [N_CH-1:0]            run,
  input logic [N_CH-1:0]            casc
);

  for (genvar i = 0; i < N_CH; i++) begin : g_a
    // R5: a pulse only follows a running step out of all-ones
    a_r5_irq_after_wrap: assert property (@(posedge clk) disable iff (rst)
      irq[i] |-> ($past(cnt[i]) == {CNT_W{1'b1}} && $past(run[i])));

    // R10: stopped channel keeps its count unless it is being started
    a_r10_idle_holds: assert property (@(posedge clk) disable iff (rst)
      !run[i] |=> (run[i] || $stable(cnt[i])));

    // R4, R3: a running count moves by one or wraps to reload, never jumps
    a_r4_step_bounded: assert property (@(posedge clk) disable iff (rst)
      run[i] |=> (cnt[i] == $past(cnt[i]) ||
                  cnt[i] == CNT_W'($past(cnt[i]) + 1'b1) ||
                  ($past(cnt[i]) == {CNT_W{1'b1}} && cnt[i] == $past(reload[i]))));

    // R2: start takes the reload value
    a_r2_start_loads: assert property (@(posedge clk) disable iff (rst)
      $rose(run[i]) |-> (cnt[i] == $past(reload[i])));
  end

  // R8: chained channel 0 has no source
  a_r8_ch0_chain_frozen: assert property (@(posedge clk) disable iff (rst)
    (run[0] && casc[0]) |=> $stable(cnt[0]));

endmodule

bind timer_bank timer_bank_chk #(.N_CH(N_CH), .CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .irq    (irq),
  .cnt    (cnt_v),
  .reload (reload_v),
  .run    (run_v),
  .casc   (casc_v)
);

// File: tb/timer_bank_bench.sv
module timer_bank_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_ctrl = 1'b0;
  logic [1:0]  wr_ch = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_ch = '0;
  logic [15:0] rd_data;
  logic [3:0]  irq;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  localparam logic [15:0] RUN = 16'h0080;
  localparam logic [15:0] IEN = 16'h0040;
  localparam logic [15:0] CHN = 16'h0004;

  // {divider select, reload, tick_en cycles}
  localparam logic [33:0] VECS [6] = '{
    {2'd0, 16'h0000, 16'd5},
    {2'd0, 16'hFFFD, 16'd5},
    {2'd1, 16'h0100, 16'd200},
    {2'd2, 16'hFFFF, 16'd600},
    {2'd3, 16'h0042, 16'd2100},
    {2'd1, 16'h0000, 16'd63}
  };

  always #10 clk = ~clk;

  timer_bank u_timer_bank (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .wr_ctrl(wr_ctrl),
    .wr_ch(wr_ch), .wr_data(wr_data), .rd_ch(rd_ch), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input bit is_ctrl, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_ctrl = is_ctrl; wr_ch = ch[1:0]; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic rd(input int ch, output logic [15:0] v);
    rd_ch = ch[1:0];
    @(negedge clk);
    v = rd_data;
  endtask

  function automatic logic [15:0] model(input logic [1:0] ps, input logic [15:0] rl, input int nt);
    int sh;
    logic [15:0] v;
    sh = (ps == 2'd0) ? 0 : (ps == 2'd1) ? 6 : (ps == 2'd2) ? 8 : 10;
    v = rl;
    for (int k = 0; k < (nt >> sh); k++) v = (v == 16'hFFFF) ? rl : v + 16'd1;
    return v;
  endfunction

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    logic [15:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 rd_data", {16'h0, rd_data}, 32'h0);
    chk("R11 irq", {28'h0, irq}, 32'h0);
    rd(2, v);
    chk("R11 count ch2", {16'h0, v}, 32'h0);

    // R1 R4 R10: table of divider / reload / tick patterns on channel 0
    for (int i = 0; i < 6; i++) begin
      logic [1:0]  ps;
      logic [15:0] rl;
      logic [15:0] nt;
      {ps, rl, nt} = VECS[i];
      wr(0, 1'b1, 16'h0000);
      wr(0, 1'b0, rl);
      wr(0, 1'b1, RUN | {14'h0, ps});
      ticks(int'(nt));
      wr(0, 1'b1, {14'h0, ps});
      rd(0, v);
      chk("R1 R4 table count", {16'h0, v}, {16'h0, model(ps, rl, int'(nt))});
      held = v;
      ticks(5);
      rd(0, v);
      chk("R10 stopped holds", {16'h0, v}, {16'h0, held});
    end

    // R2: start loads reload
    wr(1, 1'b0, 16'h1000);
    wr(1, 1'b1, RUN);
    rd(1, v);
    chk("R2 start loads", {16'h0, v}, 32'h1000);
    wr(1, 1'b1, 16'h0000);

    // R9: reload written while running
    wr(1, 1'b0, 16'hFFFE);
    wr(1, 1'b1, RUN);
    wr(1, 1'b0, 16'h0500);
    ticks(1);
    rd(1, v);
    chk("R9 count untouched by reload write", {16'h0, v}, 32'hFFFF);
    ticks(1);
    rd(1, v);
    chk("R9 new reload at overflow", {16'h0, v}, 32'h0500);

    // R3: control rewrite while running, divider 1024 now
    wr(1, 1'b1, RUN | 16'h0003);
    rd(1, v);
    chk("R3 no reload on rewrite", {16'h0, v}, 32'h0500);
    ticks(10);
    rd(1, v);
    chk("R3 new divider applied", {16'h0, v}, 32'h0500);
    wr(1, 1'b1, 16'h0000);

    // R5: interrupt pulse
    wr(0, 1'b1, 16'h0000);
    wr(0, 1'b0, 16'hFFFF);
    wr(0, 1'b1, RUN | IEN);
    ticks(1);
    chk("R5 irq on overflow", {28'h0, irq}, 32'h1);
    @(negedge clk);
    chk("R5 irq one cycle", {28'h0, irq}, 32'h0);
    wr(0, 1'b1, 16'h0000);
    wr(0, 1'b1, RUN);
    ticks(1);
    chk("R5 no irq when disabled", {28'h0, irq}, 32'h0);
    rd(0, v);
    chk("R4 reload after wrap", {16'h0, v}, 32'hFFFF);

    // R6 R7: chain
    wr(0, 1'b1, 16'h0000);
    wr(0, 1'b0, 16'hFFFE);
    wr(1, 1'b0, 16'hFFFF);
    wr(2, 1'b0, 16'h0010);
    wr(3, 1'b0, 16'hFFFF);
    wr(1, 1'b1, RUN | IEN | CHN);
    wr(2, 1'b1, RUN | IEN | CHN);
    wr(3, 1'b1, RUN | IEN | CHN);
    wr(0, 1'b1, RUN | IEN);
    ticks(1);
    chk("R6 no irq before carry", {28'h0, irq}, 32'h0);
    rd(1, v);
    chk("R6 chained ignores ticks", {16'h0, v}, 32'hFFFF);
    ticks(1);
    chk("R7 ripple stops at ch2", {28'h0, irq}, 32'h3);
    rd(1, v);
    chk("R7 ch1 reloaded", {16'h0, v}, 32'hFFFF);
    rd(2, v);
    chk("R7 ch2 advanced", {16'h0, v}, 32'h0011);
    rd(3, v);
    chk("R7 ch3 unchanged", {16'h0, v}, 32'hFFFF);

    wr(2, 1'b1, 16'h0000);
    wr(2, 1'b0, 16'hFFFF);
    wr(2, 1'b1, RUN | IEN | CHN);
    ticks(2);
    chk("R7 full ripple irq", {28'h0, irq}, 32'hF);
    rd(2, v);
    chk("R7 ch2 reloaded", {16'h0, v}, 32'hFFFF);

    // R8: ch3 carries nowhere; chained ch0 frozen
    wr(0, 1'b1, 16'h0000);
    wr(0, 1'b1, RUN | CHN);
    wr(3, 1'b1, 16'h0000);
    wr(3, 1'b1, RUN | IEN);
    ticks(3);
    chk("R8 only ch3 irq", {28'h0, irq}, 32'h8);
    rd(0, v);
    chk("R8 ch0 frozen", {16'h0, v}, 32'hFFFE);

    finish_run();
  end

endmodule